// File: doc/BRIEF.md
# Two-Wire Control Register Writer

This block is a write-only target on a two-wire serial control bus. It oversamples the clock and data lines with a faster system clock, spots start and stop conditions, and checks the first byte of each frame against a fixed 7-bit device address with the direction bit set to write. The next byte is taken as a register pointer. Every byte after that is stored into a bank of five 8-bit control registers, and each register drives a slice of a wide parallel output.

The block pulls the data line low to acknowledge each byte it accepts. It does this through an enable output, and the pad outside the block turns that enable into an open-drain pull-down. The pointer byte also picks how a burst behaves. In stepping mode each new data byte goes to the next register, and the pointer stops at the highest register instead of wrapping. In fixed mode every byte rewrites the same register, which suits adjusting one setting over and over.

Top module: `i2c_regwr_slave`

## Requirements
- R1: After synchronous reset all five registers read 00h, the data-line pull-down enable is low, and the block waits for a start condition.
- R2: When the address byte equals the device address followed by a 0 direction bit, the block pulls the data line low during the 9th clock of that byte.
- R3: When the upper 7 bits of the address byte differ from the device address, the block leaves the data line released for the 9th clock and for every later byte of that frame, and no register changes.
- R4: An address byte whose 7 address bits match but whose direction bit (bit 0, the last bit sent) is 1 is not acknowledged and changes no register.
- R5: Bytes are received MSB first, sampled on rising clock edges. In a frame made of address, pointer and one data byte, the data byte is stored in the register that the low 3 bits of the pointer select, and both the pointer byte and the data byte are acknowledged.
- R6: When pointer bit 7 is 0 (stepping mode), each data byte after the first goes to the register one above the previous one, so a burst that starts at pointer 00h fills registers 00h to 04h in order.
- R7: In stepping mode the pointer does not advance past 04h, so any further data bytes in the same frame overwrite register 04h.
- R8: When pointer bit 7 is 1 (fixed mode), every data byte in the frame rewrites the single register selected by pointer bits 2:0.
- R9: A pointer whose low 3 bits are 5, 6 or 7 is still acknowledged, along with its data bytes, but no register changes.
- R10: A stop or a repeated start in the middle of a byte ends that byte without any write, keeps every register already written, and a frame that follows a repeated start is handled normally.
- R11: The pull-down enable rises only after the falling clock edge of the 8th bit and is low again after the falling edge of the 9th bit, so it is never asserted while the next byte's bits are being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired level) |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge); 0 releases it |
| regs_o | output | 40 | Register contents; register k sits on bits 8k+7 down to 8k |

## Verification
The bench builds the block with its default five registers, a 3-bit pointer field and a two-stage synchroniser. With these values every pointer value from 0 to 7 can be swept in both stepping and fixed mode, using bursts of six bytes. That covers the run into the top register, the saturation at 04h and the discarded out-of-range pointers, all checked against a small arithmetic model of the register file. The bench also flips each of the seven address bits one at a time, sets the read direction bit, and cuts bytes short with a stop or a repeated start.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_SUB  = 2'd2,
        ST_DATA = 2'd3
    } phase_e;

endpackage

// File: rtl/i2c_regwr_sync.sv
module i2c_regwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_prev;
        logic              sda_prev;
    } sync_t;

    sync_t s_d, s_q;
    logic  scl_now, sda_now;

    assign scl_now = s_q.scl_sh[STAGES-1];
    assign sda_now = s_q.sda_sh[STAGES-1];

    always_comb begin
        s_d          = s_q;
        s_d.scl_sh   = {s_q.scl_sh[STAGES-2:0], scl_i};
        s_d.sda_sh   = {s_q.sda_sh[STAGES-2:0], sda_i};
        s_d.scl_prev = scl_now;
        s_d.sda_prev = sda_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.scl_sh   <= '1;
            s_q.sda_sh   <= '1;
            s_q.scl_prev <= 1'b1;
            s_q.sda_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign sda_lvl_o  = sda_now;
    assign scl_rise_o = scl_now & ~s_q.scl_prev;
    assign scl_fall_o = ~scl_now & s_q.scl_prev;
    assign start_o    = scl_now & s_q.scl_prev & s_q.sda_prev & ~sda_now;
    assign stop_o     = scl_now & s_q.scl_prev & ~s_q.sda_prev & sda_now;

endmodule

// File: rtl/i2c_regwr_ctrl.sv
module i2c_regwr_ctrl
    import i2c_regwr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h44,
    parameter int         NUM_REGS = 5,
    parameter int         SEL_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_lvl_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    output logic              sda_oe_o,
    output logic              wr_en_o,
    output logic [SEL_W-1:0]  wr_idx_o,
    output logic [BYTE_W-1:0] wr_data_o
);

    localparam logic [SEL_W-1:0] LAST_IDX  = SEL_W'(NUM_REGS - 1);
    localparam logic [3:0]       BIT_LAST  = 4'(BYTE_W);
    localparam logic [3:0]       BIT_ACK   = 4'(BYTE_W + 1);
    localparam logic [BYTE_W-1:0] ADDR_WR  = {DEV_ADDR, 1'b0};

    typedef struct packed {
        phase_e             phase;
        logic [3:0]         bitcnt;
        logic [BYTE_W-1:0]  shreg;
        logic [SEL_W-1:0]   ptr;
        logic               autoinc;
        logic               oe;
        logic               wr_en;
        logic [SEL_W-1:0]   wr_idx;
        logic [BYTE_W-1:0]  wr_data;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d       = c_q;
        c_d.wr_en = 1'b0;
        if (stop_i) begin
            c_d.phase  = ST_IDLE;
            c_d.bitcnt = '0;
            c_d.oe     = 1'b0;
        end else if (start_i) begin
            c_d.phase  = ST_ADDR;
            c_d.bitcnt = '0;
            c_d.oe     = 1'b0;
        end else if (c_q.phase != ST_IDLE) begin
            if (scl_rise_i && c_q.bitcnt < BIT_ACK) begin
                if (c_q.bitcnt < BIT_LAST) begin
                    c_d.shreg = {c_q.shreg[BYTE_W-2:0], sda_lvl_i};
                end
                c_d.bitcnt = c_q.bitcnt + 4'd1;
            end else if (scl_fall_i && c_q.bitcnt == BIT_LAST) begin
                // byte complete: decide acknowledge and act on it
                unique case (c_q.phase)
                    ST_ADDR: begin
                        if (c_q.shreg == ADDR_WR) begin
                            c_d.oe = 1'b1;
                        end else begin
                            c_d.phase = ST_IDLE;
                        end
                    end
                    ST_SUB: begin
                        c_d.oe      = 1'b1;
                        c_d.ptr     = c_q.shreg[SEL_W-1:0];
                        c_d.autoinc = ~c_q.shreg[BYTE_W-1];
                    end
                    ST_DATA: begin
                        c_d.oe = 1'b1;
                        if (c_q.ptr <= LAST_IDX) begin
                            c_d.wr_en   = 1'b1;
                            c_d.wr_idx  = c_q.ptr;
                            c_d.wr_data = c_q.shreg;
                        end
                        if (c_q.autoinc && c_q.ptr < LAST_IDX) begin
                            c_d.ptr = c_q.ptr + SEL_W'(1);
                        end
                    end
                    default: ;
                endcase
            end else if (scl_fall_i && c_q.bitcnt == BIT_ACK) begin
                c_d.oe     = 1'b0;
                c_d.bitcnt = '0;
                if (c_q.phase == ST_ADDR) begin
                    c_d.phase = ST_SUB;
                end else if (c_q.phase == ST_SUB) begin
                    c_d.phase = ST_DATA;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.phase   <= ST_IDLE;
            c_q.bitcnt  <= '0;
            c_q.shreg   <= '0;
            c_q.ptr     <= '0;
            c_q.autoinc <= 1'b1;
            c_q.oe      <= 1'b0;
            c_q.wr_en   <= 1'b0;
            c_q.wr_idx  <= '0;
            c_q.wr_data <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe_o  = c_q.oe;
    assign wr_en_o   = c_q.wr_en;
    assign wr_idx_o  = c_q.wr_idx;
    assign wr_data_o = c_q.wr_data;

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> (c_q.phase == ST_IDLE && !c_q.oe)); // R1

    AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(c_q.oe)) |-> $past(c_q.bitcnt) == BIT_LAST); // R2

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        c_q.phase == ST_IDLE |-> !c_q.oe); // R3

    AST_PTR_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && c_q.phase == ST_DATA && $past(c_q.phase) == ST_DATA && !$stable(c_q.ptr))
        |-> (c_q.autoinc && c_q.ptr == $past(c_q.ptr) + SEL_W'(1) && $past(c_q.ptr) < LAST_IDX)); // R7

    AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && c_q.phase == ST_DATA && $past(c_q.phase) == ST_DATA && !c_q.autoinc)
        |-> $stable(c_q.ptr)); // R8

    AST_OE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$stable(c_q.oe) && !$past(start_i) && !$past(stop_i))
        |-> $past(scl_fall_i)); // R11

endmodule

// File: rtl/i2c_regwr_bank.sv
module i2c_regwr_bank
    import i2c_regwr_pkg::*;
#(
    parameter int NUM_REGS = 5,
    parameter int SEL_W    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en_i,
    input  logic [SEL_W-1:0]           wr_idx_i,
    input  logic [BYTE_W-1:0]          wr_data_i,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

    localparam logic [SEL_W-1:0] LAST_IDX = SEL_W'(NUM_REGS - 1);

    logic [BYTE_W-1:0] regs_d [NUM_REGS];
    logic [BYTE_W-1:0] regs_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en_i && wr_idx_i == SEL_W'(g)) begin
                regs_d[g] = wr_data_i;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end

        assign regs_o[g*BYTE_W +: BYTE_W] = regs_q[g];
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |-> wr_idx_i <= LAST_IDX); // R9

    AST_HOLD_NO_WR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en_i)) |-> $stable(regs_o)); // R10

endmodule

// File: rtl/i2c_regwr_slave.sv
module i2c_regwr_slave
    import i2c_regwr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h44,
    parameter int         NUM_REGS    = 5,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);

    localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [SEL_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;

    i2c_regwr_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2c_regwr_ctrl #(
        .DEV_ADDR (DEV_ADDR),
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sda_lvl_i  (sda_lvl),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .sda_oe_o   (sda_oe_o),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data)
    );

    i2c_regwr_bank #(
        .NUM_REGS (NUM_REGS),
        .SEL_W    (SEL_W)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .regs_o    (regs_o)
    );

endmodule

// File: tb/i2c_regwr_slave_tb.sv
module i2c_regwr_slave_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 6;
    localparam int         NREG       = 5;
    localparam logic [6:0] ADDR       = 7'h44;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    wire  sda_line = sda_m & ~sda_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] exp_r [NREG];

    i2c_regwr_slave #(
        .DEV_ADDR (ADDR),
        .NUM_REGS (NREG)
    ) u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .regs_o   (regs)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic chk(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; waitq();
        scl   = 1'b1; waitq();
        sda_m = 1'b0; waitq();
        scl   = 1'b0; waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; waitq();
        scl   = 1'b1; waitq();
        sda_m = 1'b1; waitq();
    endtask

    task automatic send_bit(bit b);
        sda_m = b; waitq();
        scl   = 1'b1; waitq(); waitq();
        scl   = 1'b0; waitq();
    endtask

    // R11: the pull-down must be off one quarter period after the 9th fall
    task automatic send_byte(logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; waitq();
        scl   = 1'b1; waitq();
        acked = (sda_line == 1'b0);
        waitq();
        scl   = 1'b0; waitq();
        chk(sda_oe == 1'b0, "R11", "release after ack", int'(sda_oe), 0);
    endtask

    task automatic check_regs(string req);
        for (int k = 0; k < NREG; k++) begin
            chk(regs[k*8 +: 8] == exp_r[k], req, $sformatf("reg%0d", k),
                int'(regs[k*8 +: 8]), int'(exp_r[k]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        bit ack;
        for (int k = 0; k < NREG; k++) exp_r[k] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state
        check_regs("R1");
        chk(sda_oe == 1'b0, "R1", "oe after reset", int'(sda_oe), 0);

        // R2 R5: single byte write
        bus_start();
        send_byte({ADDR, 1'b0}, ack); chk(ack, "R2", "address ack", int'(ack), 1);
        send_byte(8'h03, ack);        chk(ack, "R5", "pointer ack", int'(ack), 1);
        send_byte(8'hA5, ack);        chk(ack, "R5", "data ack", int'(ack), 1);
        bus_stop();
        exp_r[3] = 8'hA5;
        check_regs("R5");

        // R6 R7 R8 R9: sweep every pointer in both modes with 6-byte bursts
        for (int mode = 0; mode < 2; mode++) begin
            for (int s = 0; s < 8; s++) begin
                logic [7:0] ptr_byte;
                int ptr;
                string tag;
                ptr_byte = {mode[0], 4'b0000, s[2:0]};
                ptr = s;
                tag = (mode == 1) ? "R8" : ((s >= NREG) ? "R9" : "R6 R7");
                bus_start();
                send_byte({ADDR, 1'b0}, ack); chk(ack, "R2", "address ack", int'(ack), 1);
                send_byte(ptr_byte, ack);     chk(ack, "R9", "pointer ack", int'(ack), 1);
                for (int k = 0; k < 6; k++) begin
                    logic [7:0] d;
                    d = 8'((s * 37 + k * 11 + mode * 91 + 7) & 8'hFF);
                    send_byte(d, ack);
                    chk(ack, tag, "data ack", int'(ack), 1);
                    if (ptr < NREG) exp_r[ptr] = d;
                    if (mode == 0 && ptr < NREG - 1) ptr++;
                end
                bus_stop();
                check_regs(tag);
            end
        end

        // R3: each single-bit address error is refused and writes nothing
        for (int i = 0; i < 7; i++) begin
            logic [6:0] wrong;
            wrong = ADDR ^ 7'(1 << i);
            bus_start();
            send_byte({wrong, 1'b0}, ack); chk(!ack, "R3", "wrong address nak", int'(ack), 0);
            send_byte(8'h01, ack);         chk(!ack, "R3", "pointer nak", int'(ack), 0);
            send_byte(8'h5A, ack);         chk(!ack, "R3", "data nak", int'(ack), 0);
            bus_stop();
            check_regs("R3");
        end

        // R4: read direction bit is refused
        bus_start();
        send_byte({ADDR, 1'b1}, ack); chk(!ack, "R4", "read bit nak", int'(ack), 0);
        send_byte(8'h02, ack);        chk(!ack, "R4", "pointer nak", int'(ack), 0);
        send_byte(8'hEE, ack);        chk(!ack, "R4", "data nak", int'(ack), 0);
        bus_stop();
        check_regs("R4");

        // R10: stop in the middle of a data byte
        bus_start();
        send_byte({ADDR, 1'b0}, ack); chk(ack, "R10", "address ack", int'(ack), 1);
        send_byte(8'h02, ack);        chk(ack, "R10", "pointer ack", int'(ack), 1);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        check_regs("R10");

        // R10: repeated start mid-byte, then a normal frame
        bus_start();
        send_byte({ADDR, 1'b0}, ack); chk(ack, "R10", "address ack", int'(ack), 1);
        send_byte(8'h01, ack);        chk(ack, "R10", "pointer ack", int'(ack), 1);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_start();
        send_byte({ADDR, 1'b0}, ack); chk(ack, "R10", "address after restart", int'(ack), 1);
        send_byte(8'h00, ack);        chk(ack, "R10", "pointer after restart", int'(ack), 1);
        send_byte(8'h3C, ack);        chk(ack, "R10", "data after restart", int'(ack), 1);
        bus_stop();
        exp_r[0] = 8'h3C;
        check_regs("R10");

        summary();
    end

endmodule